// File: doc/BRIEF.md
# Double-Buffered Nine-Bit Serial Transmitter

This block turns characters into asynchronous serial frames on a single output line. Each frame has eleven bit cells: a low start cell, eight data cells sent least significant bit first, a ninth bit chosen per character, and a high stop cell. Bit timing comes from an external enable pulse, `tick`, that runs at sixteen times the baud rate. The block contains no baud divider.

A writer presents a byte and its ninth bit together with a one-cycle strobe. A single holding stage sits in front of the shift register, so the next character can be queued while the current frame is still on the line. A queued character moves into the shifter on the same tick that ends the current stop cell. Consecutive frames are therefore separated by exactly one stop cell. The writer reads `buf_full` to see whether the holding stage is occupied. It receives one `tx_done` pulse per completed frame and one `wr_collide` pulse for each write that had to be dropped.

Top module: `uart9_tx`

## Requirements
- R1: After reset, and whenever no frame is being shifted, `txd` is high. After reset `buf_full`, `tx_done` and `wr_collide` are low.
- R2: A frame is, in line order: start cell 0, data bit 0 through data bit 7, the ninth bit, stop cell 1.
- R3: Every cell lasts exactly 16 `tick` pulses. With no tick, `txd` does not change while a frame is active.
- R4: The ninth bit sent is the value of `wr_nine` in the write cycle. Later changes on `wr_nine` have no effect on that character.
- R5: A write accepted while a frame is shifting raises `buf_full` one clock later. `buf_full` stays high until the character moves into the shifter.
- R6: A character that is queued before the current stop cell ends starts its start cell on the tick that ends that stop cell. The starts of the two frames are then exactly 176 ticks apart.
- R7: A write made while the holding stage is full, and is not being emptied in that cycle, is dropped. `wr_collide` pulses high for one clock, and the held character is sent unchanged.
- R8: `tx_done` pulses high for one clock after the tick that ends each stop cell. That is 176 ticks after the start cell began.
- R9: A write to an idle block drives `txd` low two clock edges after the strobe, with no tick needed. `buf_full` is high for the single clock between those edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversample enable, 16 per bit cell |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Character byte |
| wr_nine | input | 1 | Ninth bit for this character |
| buf_full | output | 1 | Holding stage holds an unsent character |
| wr_collide | output | 1 | One-cycle pulse: a write was dropped |
| tx_done | output | 1 | One-cycle pulse at the end of each stop cell |
| txd | output | 1 | Serial output, idles high |

## Verification
The properties assume that `tick` and `wr_en` are synchronous to `clk`. They place no limit on how often either is high; `tick` may stop for any length of time.

The stimulus drives both signals only on falling clock edges. `tick` fires every third clock and is paused for a long stretch in one scenario. Writes are single-cycle strobes, and two strobes go out on adjacent clocks to force a collision.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    localparam int unsigned CHAR_W  = 8;
    localparam int unsigned OVS     = 16;
    localparam int unsigned FRAME_W = CHAR_W + 3;
    localparam int unsigned SUB_W   = $clog2(OVS);
    localparam int unsigned IDX_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              nine;
    } char_t;

    typedef struct packed {
        logic  valid;
        char_t ch;
        logic  collide;
    } hold_st_t;

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sreg;
        logic [SUB_W-1:0]   sub;
        logic [IDX_W-1:0]   idx;
        logic               done;
    } shift_st_t;
endpackage

// File: rtl/uart9_hold.sv
module uart9_hold
    import uart9_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  char_t wr_char,
    input  logic  take,
    output logic  valid,
    output char_t held,
    output logic  collide
);
    hold_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.collide = 1'b0;
        if (take) begin
            st_d.valid = 1'b0;
        end
        if (wr_en) begin
            if (!st_q.valid || take) begin
                st_d.valid = 1'b1;
                st_d.ch    = wr_char;
            end else begin
                st_d.collide = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid   = st_q.valid;
    assign held    = st_q.ch;
    assign collide = st_q.collide;
endmodule

// File: rtl/uart9_shift.sv
module uart9_shift
    import uart9_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  ld_ok,
    input  char_t ld_char,
    output logic  take,
    output logic  txd,
    output logic  done,
    output logic  busy,
    output logic  frame_end
);
    shift_st_t st_d, st_q;
    logic last_sub;
    logic bit_end;

    always_comb begin
        last_sub  = (st_q.sub == SUB_W'(OVS - 1));
        bit_end   = st_q.busy && tick && last_sub;
        frame_end = bit_end && (st_q.idx == IDX_W'(FRAME_W - 1));
        take      = ld_ok && (!st_q.busy || frame_end);

        st_d      = st_q;
        st_d.done = frame_end;
        if (st_q.busy && tick) begin
            st_d.sub = last_sub ? '0 : st_q.sub + 1'b1;
        end
        if (bit_end && !frame_end) begin
            st_d.sreg = {1'b1, st_q.sreg[FRAME_W-1:1]};
            st_d.idx  = st_q.idx + 1'b1;
        end
        if (frame_end) begin
            st_d.busy = 1'b0;
        end
        if (take) begin
            st_d.busy = 1'b1;
            st_d.sreg = {1'b1, ld_char.nine, ld_char.data, 1'b0};
            st_d.sub  = '0;
            st_d.idx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.sreg <= '1;
            st_q.sub  <= '0;
            st_q.idx  <= '0;
            st_q.done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.sreg[0];
    assign done = st_q.done;
    assign busy = st_q.busy;
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_nine,
    output logic              buf_full,
    output logic              wr_collide,
    output logic              tx_done,
    output logic              txd
);
    char_t wr_char;
    char_t held;
    logic  take;
    logic  sh_busy;
    logic  frame_end;

    assign wr_char.data = wr_data;
    assign wr_char.nine = wr_nine;

    uart9_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_char (wr_char),
        .take    (take),
        .valid   (buf_full),
        .held    (held),
        .collide (wr_collide)
    );

    uart9_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ld_ok     (buf_full),
        .ld_char   (held),
        .take      (take),
        .txd       (txd),
        .done      (tx_done),
        .busy      (sh_busy),
        .frame_end (frame_end)
    );
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic wr_en,
    input logic buf_full,
    input logic wr_collide,
    input logic tx_done,
    input logic txd,
    input logic busy,
    input logic take,
    input logic frame_end
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(txd));

    a_r5_full_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !take) |=> buf_full);

    a_r6_start_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && take) |=> (busy && !txd));

    a_r7_collide_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_full && !take) |=> wr_collide);

    a_r7_collide_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_collide |-> $past(wr_en));

    a_r8_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> tx_done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);
endmodule

bind uart9_tx uart9_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .buf_full   (buf_full),
    .wr_collide (wr_collide),
    .tx_done    (tx_done),
    .txd        (txd),
    .busy       (sh_busy),
    .take       (take),
    .frame_end  (frame_end)
);

// File: tb/tb_uart9_tx.sv
module tb_uart9_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_nine = 1'b0;
    logic       buf_full, wr_collide, tx_done, txd;

    uart9_tx dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_nine(wr_nine), .buf_full(buf_full),
        .wr_collide(wr_collide), .tx_done(tx_done), .txd(txd)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int ticks_seen = 0;
    int tdiv = 0;
    bit tick_run = 1'b1;
    int done_cnt = 0;
    int coll_cnt = 0;
    int done_t [0:31];
    bit rx_act = 1'b0;
    int ph = 0;
    logic [10:0] bits;
    int rx_n = 0;
    logic [7:0] rx_data [0:31];
    logic       rx_nine [0:31];
    logic       rx_ok [0:31];
    int         rx_t [0:31];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
        if (tick) ticks_seen++;
        if (tx_done) begin
            if (done_cnt < 32) done_t[done_cnt] = ticks_seen;
            done_cnt++;
        end
        if (wr_collide) coll_cnt++;
        if (!rx_act) begin
            if (rst_n && txd == 1'b0) begin
                rx_act = 1'b1;
                ph = 0;
                if (rx_n < 32) rx_t[rx_n] = ticks_seen;
            end
        end else if (tick) begin
            ph++;
            if (ph % 16 == 8) begin
                bits[ph/16] = txd;
                if (ph / 16 == 10) begin
                    if (rx_n < 32) begin
                        rx_data[rx_n] = bits[8:1];
                        rx_nine[rx_n] = bits[9];
                        rx_ok[rx_n]   = (bits[0] == 1'b0) && (bits[10] == 1'b1);
                    end
                    rx_n++;
                    rx_act = 1'b0;
                end
            end
        end
        if (tick_run) begin
            tdiv = (tdiv + 1) % 3;
            tick = (tdiv == 0);
        end else begin
            tick = 1'b0;
        end
    end

    task automatic write_char(input logic [7:0] d, input logic n);
        wr_en   = 1'b1;
        wr_data = d;
        wr_nine = n;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (rx_n < n || rx_act) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset;
        check(txd == 1'b1, "R1 txd after reset", txd, 1);
        check(buf_full == 1'b0, "R1 buf_full after reset", buf_full, 0);
        check(tx_done == 1'b0 && wr_collide == 1'b0, "R1 pulses after reset", tx_done + wr_collide, 0);
    endtask

    task automatic t_single;
        int n0 = rx_n;
        int d0 = done_cnt;
        write_char(8'h3A, 1'b1);
        check(buf_full == 1'b1 && txd == 1'b1, "R9 one clock after write", {buf_full, txd}, 3);
        @(negedge clk);
        check(txd == 1'b0, "R9 start cell two clocks after write", txd, 0);
        check(buf_full == 1'b0, "R9 buf_full cleared on load", buf_full, 0);
        wait_frames(n0 + 1);
        check(rx_data[n0] == 8'h3A, "R2 data bits", rx_data[n0], 8'h3A);
        check(rx_nine[n0] == 1'b1, "R4 ninth bit one", rx_nine[n0], 1);
        check(rx_ok[n0] == 1'b1, "R2 start and stop cells", rx_ok[n0], 1);
        check(done_cnt == d0 + 1, "R8 one done pulse", done_cnt, d0 + 1);
        check(done_t[d0] - rx_t[n0] == 176, "R3 frame length in ticks", done_t[d0] - rx_t[n0], 176);
        check(txd == 1'b1, "R1 idle after frame", txd, 1);
    endtask

    task automatic t_lsb;
        int n0 = rx_n;
        write_char(8'h01, 1'b0);
        wait_frames(n0 + 1);
        check(rx_data[n0] == 8'h01, "R2 lsb first", rx_data[n0], 8'h01);
        check(rx_nine[n0] == 1'b0, "R4 ninth bit zero", rx_nine[n0], 0);
    endtask

    task automatic t_b2b;
        int n0 = rx_n;
        int d0 = done_cnt;
        write_char(8'hC6, 1'b1);
        repeat (3) @(negedge clk);
        repeat (60) @(negedge clk);
        write_char(8'h96, 1'b0);
        wr_nine = 1'b1;
        check(buf_full == 1'b1, "R5 buf_full after queued write", buf_full, 1);
        repeat (200) @(negedge clk);
        check(buf_full == 1'b1, "R5 buf_full held while shifting", buf_full, 1);
        wait_frames(n0 + 2);
        wr_nine = 1'b0;
        check(rx_data[n0] == 8'hC6 && rx_data[n0+1] == 8'h96, "R6 both characters", rx_data[n0+1], 8'h96);
        check(rx_nine[n0+1] == 1'b0, "R4 ninth bit latched at write", rx_nine[n0+1], 0);
        check(rx_t[n0+1] - rx_t[n0] == 176, "R6 single stop cell gap", rx_t[n0+1] - rx_t[n0], 176);
        check(done_cnt == d0 + 2, "R8 done per frame", done_cnt, d0 + 2);
        check(buf_full == 1'b0, "R5 buf_full clear when drained", buf_full, 0);
    endtask

    task automatic t_collide;
        int n0 = rx_n;
        int c0 = coll_cnt;
        write_char(8'h5B, 1'b0);
        repeat (4) @(negedge clk);
        write_char(8'h71, 1'b1);
        write_char(8'hEE, 1'b0);
        @(negedge clk);
        check(coll_cnt == c0 + 1, "R7 collide pulse", coll_cnt, c0 + 1);
        wait_frames(n0 + 2);
        repeat (700) @(negedge clk);
        check(rx_n == n0 + 2, "R7 dropped write not sent", rx_n, n0 + 2);
        check(rx_data[n0+1] == 8'h71 && rx_nine[n0+1] == 1'b1, "R7 held character intact", rx_data[n0+1], 8'h71);
    endtask

    task automatic t_idle_gap;
        int n0 = rx_n;
        check(txd == 1'b1, "R1 line high between bursts", txd, 1);
        write_char(8'hA4, 1'b1);
        wait_frames(n0 + 1);
        check(rx_t[n0] - rx_t[n0-1] > 176, "R6 gap only when late", rx_t[n0] - rx_t[n0-1], 177);
        check(rx_data[n0] == 8'hA4, "R2 data after idle", rx_data[n0], 8'hA4);
    endtask

    task automatic t_tick_pause;
        int n0 = rx_n;
        int d0 = done_cnt;
        @(negedge clk);
        tick_run = 1'b0;
        @(negedge clk);
        write_char(8'h2D, 1'b0);
        @(negedge clk);
        repeat (300) @(negedge clk);
        check(txd == 1'b0, "R3 start cell held without tick", txd, 0);
        check(done_cnt == d0, "R3 no progress without tick", done_cnt, d0);
        tick_run = 1'b1;
        wait_frames(n0 + 1);
        check(rx_data[n0] == 8'h2D && rx_ok[n0] == 1'b1, "R3 frame after pause", rx_data[n0], 8'h2D);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_single;
        t_lsb;
        t_b2b;
        t_collide;
        t_idle_gap;
        t_tick_pause;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule